// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block decides, once per cycle, whether the single decoded instruction at the issue stage of an in-order pipeline may dispatch. The pipeline has four functional unit classes with different latencies. The block keeps one busy indication per unit and one write-pending bit per architectural register. It dispatches the instruction only when its unit is free, when neither source is waiting on an outstanding write, and when its destination has no write already in flight. There is no write-after-read check, because the functional units latch their operands when the instruction dispatches.

Inside each unit, the block models the pipeline stages as valid/destination pairs that move along with each instruction. It grants one completion per cycle and reports it on a write-back port. A granted completion clears the pending bit of its destination. Operand values, the register file, bypassing and exceptions belong to the surrounding pipeline.

Top module: `inorder_scoreboard`

## Requirements
- R1: After reset, every register's pending bit is 0, no unit reports busy, no write-back is reported and the stall output is low.
- R2: An instruction dispatches only when the busy bit of its target unit is clear. Unit class encoding: 0 integer/memory, 1 add, 2 multiply, 3 divide. `unit_busy_o` bit k belongs to class k.
- R3: If the pending bit of either source register is set, the instruction does not dispatch. `stall_o` is high in every cycle where a valid instruction fails to dispatch.
- R4: If the pending bit of the destination register is set and that register is not being written back in the same cycle, the instruction does not dispatch.
- R5: No write-after-read check is made. An instruction whose destination is a source of an instruction still in flight dispatches.
- R6: A dispatch sets the destination's pending bit from the next cycle onward. A write-back clears it from the cycle after the write-back.
- R7: An instruction dispatched in cycle c appears on the write-back port in cycle c+L, together with its destination, when it meets no contention. L is 1 for integer, 1 for add, 3 for multiply and 4 for divide.
- R8: The multiplier accepts a new instruction in every cycle. The divider is busy from the cycle after its dispatch through the cycle of its write-back.
- R9: At most one write-back occurs per cycle. The priority is divide, then multiply, then add, then integer. A unit that loses holds its result and destination and reports busy while it holds them.
- R10: If the destination of an instruction is being written back in the same cycle, the instruction may dispatch. The new pending bit then wins over the clear, and the bit reads 1 in the next cycle.
- R11: The source check does not see a write-back of the same cycle. A source that is being written back still stalls the instruction in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | A decoded instruction is present |
| in_unit_i | input | 2 | Target unit class (0 int, 1 add, 2 mul, 3 div) |
| in_dst_i | input | 5 | Destination register |
| in_src1_i | input | 5 | First source register |
| in_src2_i | input | 5 | Second source register |
| issue_o | output | 1 | Instruction dispatches this cycle |
| stall_o | output | 1 | Valid instruction held this cycle |
| unit_busy_o | output | 4 | Per-unit busy bits |
| pend_o | output | 32 | Per-register write-pending bits |
| wb_valid_o | output | 1 | A write-back completes this cycle |
| wb_dst_o | output | 5 | Register written back |

## Verification
The assertions check the following on every cycle: a dispatch never targets a busy unit, every dispatch leaves its destination pending, a clear without a colliding set leaves the bit low, at most one unit is granted, a held result keeps its destination, and the divider stays occupied until its last count. Only the directed scenarios can show the exact write-back cycle of each latency, the stall spans caused by source and destination hazards, and the missing write-after-read check. The scenarios also cover the release of a destination in its own write-back cycle, the lack of source forwarding, and the order in which colliding completions drain.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;

  localparam int NUM_UNITS = 4;
endpackage

// File: rtl/sb_unit_pipe.sv
module sb_unit_pipe #(
  parameter int LAT       = 1,
  parameter bit PIPELINED = 1'b1,
  parameter int REG_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             grant_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [REG_W-1:0] done_dst_o
);

  generate
    if (PIPELINED) begin : g_pipe
      logic [LAT-1:0]            v_q;
      logic [LAT-1:0][REG_W-1:0] d_q;
      logic                      adv;

      // whole chain freezes while the last stage waits for write-back
      assign adv = !(v_q[LAT-1] && !grant_i);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q <= '0;
          d_q <= '0;
        end else if (adv) begin
          v_q[0] <= accept_i;
          d_q[0] <= dst_i;
          for (int k = 1; k < LAT; k++) begin
            v_q[k] <= v_q[k-1];
            d_q[k] <= d_q[k-1];
          end
        end
      end

      assign busy_o     = !adv;
      assign done_o     = v_q[LAT-1];
      assign done_dst_o = d_q[LAT-1];
    end else begin : g_iter
      localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
      logic             v_q;
      logic [REG_W-1:0] d_q;
      logic [CW-1:0]    cnt_q;
      logic             last;

      assign last = (cnt_q == CW'(LAT - 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q   <= 1'b0;
          d_q   <= '0;
          cnt_q <= '0;
        end else if (v_q && last && grant_i) begin
          v_q <= 1'b0;
        end else if (!v_q && accept_i) begin
          v_q   <= 1'b1;
          d_q   <= dst_i;
          cnt_q <= '0;
        end else if (v_q && !last) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign busy_o     = v_q;
      assign done_o     = v_q && last;
      assign done_dst_o = d_q;

      p_iter_occupied_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (v_q && !last) |=> v_q)
        else $error("divider released before its last count");
    end
  endgenerate

  p_hold_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !grant_i) |=> (done_o && done_dst_o == $past(done_dst_o)))
    else $error("ungranted result was not held");

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
  parameter int N     = 4,
  parameter int REG_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N-1:0]            req_i,
  input  logic [N-1:0][REG_W-1:0] dst_i,
  output logic [N-1:0]            grant_o,
  output logic                    wb_valid_o,
  output logic [REG_W-1:0]        wb_dst_o
);

  // highest index wins
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    wb_dst_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) wb_dst_o = dst_i[i];
    end
  end

  assign wb_valid_o = |req_i;

  p_one_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o))
    else $error("more than one write-back granted");

endmodule

// File: rtl/sb_pend_table.sv
module sb_pend_table #(
  parameter int REG_W = 5,
  localparam int NREG = 1 << REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [REG_W-1:0] set_idx_i,
  input  logic             clr_en_i,
  input  logic [REG_W-1:0] clr_idx_i,
  output logic [NREG-1:0]  pend_o
);

  logic [NREG-1:0] pend_q;
  logic [NREG-1:0] clr_mask, set_mask;

  assign clr_mask = clr_en_i ? (NREG'(1) << clr_idx_i) : '0;
  assign set_mask = set_en_i ? (NREG'(1) << set_idx_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_mask) | set_mask;
  end

  assign pend_o = pend_q;

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !(set_en_i && set_idx_i == clr_idx_i)) |=> !pend_q[$past(clr_idx_i)])
    else $error("pending bit survived write-back");

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> pend_q[$past(set_idx_i)])
    else $error("pending bit not set after dispatch");

endmodule

// File: rtl/inorder_scoreboard.sv
module inorder_scoreboard #(
  parameter int REG_W   = 5,
  parameter int INT_LAT = 1,
  parameter int ADD_LAT = 1,
  parameter int MUL_LAT = 3,
  parameter int DIV_LAT = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic [1:0]             in_unit_i,
  input  logic [REG_W-1:0]       in_dst_i,
  input  logic [REG_W-1:0]       in_src1_i,
  input  logic [REG_W-1:0]       in_src2_i,
  output logic                   issue_o,
  output logic                   stall_o,
  output logic [3:0]             unit_busy_o,
  output logic [(1<<REG_W)-1:0]  pend_o,
  output logic                   wb_valid_o,
  output logic [REG_W-1:0]       wb_dst_o
);
  import sb_pkg::*;

  localparam int NREG = 1 << REG_W;

  logic [NUM_UNITS-1:0]            busy, req, grant;
  logic [NUM_UNITS-1:0][REG_W-1:0] req_dst;
  logic [NREG-1:0]                 pend;
  logic                            wb_valid;
  logic [REG_W-1:0]                wb_dst;
  logic                            raw_haz, waw_haz;
  unit_e                           unit;

  assign unit = unit_e'(in_unit_i);

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      localparam int LAT = (u == int'(UNIT_DIV)) ? DIV_LAT :
                           (u == int'(UNIT_MUL)) ? MUL_LAT :
                           (u == int'(UNIT_ADD)) ? ADD_LAT : INT_LAT;
      sb_unit_pipe #(
        .LAT      (LAT),
        .PIPELINED(u != int'(UNIT_DIV)),
        .REG_W    (REG_W)
      ) u_unit (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .accept_i  (issue_o && (in_unit_i == 2'(u))),
        .dst_i     (in_dst_i),
        .grant_i   (grant[u]),
        .busy_o    (busy[u]),
        .done_o    (req[u]),
        .done_dst_o(req_dst[u])
      );
    end
  endgenerate

  sb_wb_arbiter #(.N(NUM_UNITS), .REG_W(REG_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .dst_i     (req_dst),
    .grant_o   (grant),
    .wb_valid_o(wb_valid),
    .wb_dst_o  (wb_dst)
  );

  // no forwarding: sources see registered pending bits only
  assign raw_haz = pend[in_src1_i] || pend[in_src2_i];
  // destination released by a write-back completing this cycle
  assign waw_haz = pend[in_dst_i] && !(wb_valid && wb_dst == in_dst_i);

  assign issue_o = in_valid_i && !busy[unit] && !raw_haz && !waw_haz;
  assign stall_o = in_valid_i && !issue_o;

  sb_pend_table #(.REG_W(REG_W)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (issue_o),
    .set_idx_i(in_dst_i),
    .clr_en_i (wb_valid),
    .clr_idx_i(wb_dst),
    .pend_o   (pend)
  );

  assign unit_busy_o = busy;
  assign pend_o      = pend;
  assign wb_valid_o  = wb_valid;
  assign wb_dst_o    = wb_dst;

  p_no_busy_issue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> !unit_busy_o[in_unit_i])
    else $error("dispatch to busy unit");

  p_issue_marks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> pend_o[$past(in_dst_i)])
    else $error("dispatch left destination not pending");

endmodule

// File: tb/inorder_scoreboard_bench.sv
module inorder_scoreboard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0;
  logic [1:0]  un = 2'd0;
  logic [4:0]  d = 5'd0, s1 = 5'd0, s2 = 5'd0;
  logic        issue, stall, wb_valid;
  logic [3:0]  busy;
  logic [31:0] pend;
  logic [4:0]  wb_dst;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [1:0] U_INT = 2'd0, U_ADD = 2'd1, U_MUL = 2'd2, U_DIV = 2'd3;

  always #10 clk = ~clk;

  inorder_scoreboard u_inorder_scoreboard (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(v), .in_unit_i(un),
    .in_dst_i(d), .in_src1_i(s1), .in_src2_i(s2),
    .issue_o(issue), .stall_o(stall), .unit_busy_o(busy), .pend_o(pend),
    .wb_valid_o(wb_valid), .wb_dst_o(wb_dst)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // apply one cycle's input; outputs are sampled mid-low-phase
  task automatic cyc(input logic vv, input logic [1:0] uu, input logic [4:0] dd,
                     input logic [4:0] a, input logic [4:0] b);
    @(negedge clk);
    v = vv; un = uu; d = dd; s1 = a; s2 = b;
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, U_INT, 5'd0, 5'd0, 5'd0);
  endtask

  task automatic t_reset;
    chk(pend, 32'd0, "R1 pending after reset");
    chk(32'(busy), 32'd0, "R1 busy after reset");
    chk(32'(wb_valid), 32'd0, "R1 no write-back after reset");
    chk(32'(stall), 32'd0, "R1 stall after reset");
  endtask

  task automatic t_latency1;
    cyc(1'b1, U_INT, 5'd1, 5'd2, 5'd3);
    chk(32'(issue), 1, "R7 int dispatch");
    cyc(1'b1, U_ADD, 5'd14, 5'd2, 5'd3);
    chk(32'(issue), 1, "R7 add dispatch");
    chk(32'(pend[1]), 1, "R6 int dst pending");
    chk(32'(wb_valid), 1, "R7 int wb valid");
    chk(32'(wb_dst), 1, "R7 int wb dst");
    idle(1);
    chk(32'(pend[1]), 0, "R6 int dst cleared");
    chk(32'(wb_dst), 14, "R7 add wb dst");
    idle(4);
  endtask

  task automatic t_raw;
    cyc(1'b1, U_MUL, 5'd2, 5'd0, 5'd0);
    chk(32'(issue), 1, "R3 mul dispatch");
    cyc(1'b1, U_ADD, 5'd5, 5'd2, 5'd0);
    chk(32'(stall), 1, "R3 src1 RAW stall c1");
    cyc(1'b1, U_ADD, 5'd5, 5'd2, 5'd0);
    chk(32'(stall), 1, "R3 src1 RAW stall c2");
    cyc(1'b1, U_ADD, 5'd5, 5'd2, 5'd0);
    chk(32'(wb_dst), 2, "R7 mul wb at c+3");
    chk(32'(stall), 1, "R11 no forwarding in wb cycle");
    cyc(1'b1, U_ADD, 5'd5, 5'd2, 5'd0);
    chk(32'(issue), 1, "R3 dispatch after clear");
    idle(4);
    cyc(1'b1, U_INT, 5'd20, 5'd0, 5'd0);
    cyc(1'b1, U_ADD, 5'd21, 5'd0, 5'd20);
    chk(32'(stall), 1, "R11 src2 stalls during its wb");
    cyc(1'b1, U_ADD, 5'd21, 5'd0, 5'd20);
    chk(32'(issue), 1, "R3 src2 dispatch after clear");
    idle(4);
  endtask

  task automatic t_waw;
    cyc(1'b1, U_MUL, 5'd4, 5'd0, 5'd0);
    cyc(1'b1, U_INT, 5'd4, 5'd0, 5'd0);
    chk(32'(stall), 1, "R4 WAW stall c1");
    cyc(1'b1, U_INT, 5'd4, 5'd0, 5'd0);
    chk(32'(stall), 1, "R4 WAW stall c2");
    cyc(1'b1, U_INT, 5'd4, 5'd0, 5'd0);
    chk(32'(issue), 1, "R10 dispatch in dst wb cycle");
    idle(1);
    chk(32'(pend[4]), 1, "R10 set wins over clear");
    chk(32'(wb_dst), 4, "R7 second writer wb");
    idle(1);
    chk(32'(pend[4]), 0, "R6 cleared after second wb");
    idle(3);
  endtask

  task automatic t_war;
    cyc(1'b1, U_MUL, 5'd6, 5'd7, 5'd8);
    cyc(1'b1, U_INT, 5'd7, 5'd9, 5'd9);
    chk(32'(issue), 1, "R5 no WAR stall");
    idle(5);
  endtask

  task automatic t_div;
    cyc(1'b1, U_DIV, 5'd10, 5'd0, 5'd0);
    chk(32'(issue), 1, "R2 div dispatch");
    cyc(1'b1, U_DIV, 5'd11, 5'd0, 5'd0);
    chk(32'(busy[3]), 1, "R8 div busy c+1");
    chk(32'(stall), 1, "R2 div structural stall");
    cyc(1'b1, U_DIV, 5'd11, 5'd0, 5'd0);
    cyc(1'b1, U_DIV, 5'd11, 5'd0, 5'd0);
    chk(32'(stall), 1, "R8 div still busy c+3");
    cyc(1'b1, U_DIV, 5'd11, 5'd0, 5'd0);
    chk(32'(busy[3]), 1, "R8 div busy in wb cycle");
    chk(32'(wb_dst), 10, "R7 div wb at c+4");
    cyc(1'b1, U_DIV, 5'd11, 5'd0, 5'd0);
    chk(32'(issue), 1, "R8 div free after wb");
    idle(8);
  endtask

  task automatic t_mul_pipe;
    cyc(1'b1, U_MUL, 5'd12, 5'd0, 5'd0);
    cyc(1'b1, U_MUL, 5'd13, 5'd0, 5'd0);
    chk(32'(issue), 1, "R8 mul back-to-back");
    idle(1);
    idle(1);
    chk(32'(wb_dst), 12, "R7 first mul wb");
    idle(1);
    chk(32'(wb_dst), 13, "R8 second mul wb");
    idle(3);
  endtask

  task automatic t_arb;
    cyc(1'b1, U_DIV, 5'd15, 5'd0, 5'd0);
    cyc(1'b1, U_MUL, 5'd16, 5'd0, 5'd0);
    idle(1);
    cyc(1'b1, U_INT, 5'd17, 5'd0, 5'd0);
    cyc(1'b1, U_INT, 5'd18, 5'd0, 5'd0);
    chk(32'(wb_dst), 15, "R9 div wins");
    chk(32'(busy[2]), 1, "R9 mul held busy");
    chk(32'(busy[0]), 1, "R9 int held busy");
    chk(32'(stall), 1, "R9 int stall while held");
    cyc(1'b1, U_INT, 5'd18, 5'd0, 5'd0);
    chk(32'(wb_dst), 16, "R9 mul before int");
    chk(32'(stall), 1, "R9 int still held");
    cyc(1'b1, U_INT, 5'd18, 5'd0, 5'd0);
    chk(32'(wb_dst), 17, "R9 int drains last");
    chk(32'(issue), 1, "R9 int frees on grant");
    idle(1);
    chk(32'(wb_dst), 18, "R9 follow-on int wb");
    idle(3);
    chk(pend, 32'd0, "R6 all pending drained");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    t_reset();
    t_latency1();
    t_raw();
    t_waw();
    t_war();
    t_div();
    t_mul_pipe();
    t_arb();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule